// File: doc/BRIEF.md
# Power-Mode Sequencer

This block tracks which power state a small microcontroller is in and drives the clock-gating enables that follow from it. It watches an active-low reset pin, an active-low hardware-standby pin and a one-cycle strobe raised when the processor runs its sleep instruction. Three control bits shape how a strobe is handled: standby select, all-clock-stop enable and a sleep-inhibit bit. A 32-bit module-stop vector also takes part in that choice. Once the block is in a low-power state, it watches the interrupt sources that are allowed to end that state.

Each low-power state has its own set of wake sources. Light sleep accepts any interrupt. The all-clock-stop state accepts NMI, the IRQ lines, the watchdog and the 8-bit timers, but a timer request counts only when its module-stop field is clear. Software standby accepts only NMI and the IRQ lines that have their standby wake enable set. Every pin is a plain level or strobe with no handshake, so nothing at the block's edge can stall. The outputs are decoded from the state register and change one clock edge after the input that causes the change.

Top module: `pwr_mode_seq`

## Requirements
- R1: `mode` encodes the state as RESET=0, RUN=1, DOZE=2, ALLSTOP=3, SWSTBY=4, HWSTBY=5. With `stby_n` high, `rst_n` low moves any state other than HWSTBY to RESET at the next edge. RESET with `rst_n` high moves to RUN.
- R2: `stby_n` low moves every state to HWSTBY at the next edge, even while `rst_n` is low.
- R3: HWSTBY is held while `stby_n` is low. It is also held while `stby_n` is high and `rst_n` is high. It moves to RESET only when `stby_n` is high and `rst_n` is low.
- R4: In RUN, a `sleep_stb` pulse changes nothing while `slp_inhibit` is 1.
- R5: In RUN, a strobe with `sby_sel`=0 enters DOZE. It enters ALLSTOP instead when `acs_en`=1 and `mstop` has every bit set except bits 27:24, which are don't-care.
- R6: In RUN, a strobe with `sby_sel`=1 enters SWSTBY, whatever the values of `acs_en` and `mstop`.
- R7: DOZE returns to RUN on NMI, any IRQ line, any timer line or the watchdog.
- R8: ALLSTOP returns to RUN on NMI, any IRQ line or the watchdog. A timer line wakes it only while `mstop[11:8]` is 0000.
- R9: SWSTBY returns to RUN only on NMI, or on an IRQ line n whose `irq_wake_en[n]` is 1. Timers, the watchdog and unenabled IRQ lines leave it in SWSTBY.
- R10: Reset takes precedence over a sleep strobe or a wake event in the same cycle.
- R11: `cpu_clk_en` is 1 only in RUN. `per_clk_en` is 0 in ALLSTOP, SWSTBY and HWSTBY. `osc_en` is 0 only in SWSTBY and HWSTBY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low |
| stby_n | input | 1 | Hardware standby pin, active low |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| sby_sel | input | 1 | 1 selects software standby on a strobe |
| acs_en | input | 1 | All-clock-stop enable |
| slp_inhibit | input | 1 | 1 makes a strobe have no effect |
| mstop | input | 32 | Combined module-stop vector |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | 12 | External IRQ lines |
| irq_wake_en | input | 12 | Per-line software-standby wake enables |
| tmr_irq | input | NUM_TMR | 8-bit timer interrupt requests |
| wdt_irq | input | 1 | Watchdog interrupt |
| mode | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The bench builds the block with the default twelve IRQ lines and a 32-bit stop vector, and narrows the timer bank to two lines. With those sizes, the highest IRQ line, both timer channels and both ends of the don't-care nibble can be driven directly. The vector table enters each low-power state through its own strobe pattern and then offers it one wake source. Directed tests then change the stop field while ALLSTOP is active, and they drive the reset and standby pins against each other.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PM_RESET   = 3'd0,
    PM_RUN     = 3'd1,
    PM_DOZE    = 3'd2,
    PM_ALLSTOP = 3'd3,
    PM_SWSTBY  = 3'd4,
    PM_HWSTBY  = 3'd5
  } pm_state_e;
endpackage

// File: rtl/pwr_sleep_decode.sv
module pwr_sleep_decode
  import pwr_pkg::*;
#(
  parameter int MSTOP_W = 32,
  parameter int DC_LO   = 24,
  parameter int DC_HI   = 27
) (
  input  logic               sby_sel,
  input  logic               acs_en,
  input  logic [MSTOP_W-1:0] mstop,
  output pm_state_e          target
);
  function automatic logic [MSTOP_W-1:0] care_bits();
    logic [MSTOP_W-1:0] m;
    for (int i = 0; i < MSTOP_W; i++) m[i] = !(i >= DC_LO && i <= DC_HI);
    return m;
  endfunction

  localparam logic [MSTOP_W-1:0] CARE = care_bits();

  logic pattern_hit;

  always_comb begin
    pattern_hit = ((mstop & CARE) == CARE);
    if (sby_sel)                    target = PM_SWSTBY;
    else if (acs_en && pattern_hit) target = PM_ALLSTOP;
    else                            target = PM_DOZE;
  end

  always_comb begin
    if (target == PM_ALLSTOP)
      AST_ACS_PATTERN: assert (acs_en && !sby_sel && mstop[DC_LO-1:0] == '1 && mstop[MSTOP_W-1:DC_HI+1] == '1); // R5
  end
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
  parameter int NUM_IRQ = 12,
  parameter int NUM_TMR = 4,
  parameter int TS_W    = 4
) (
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  input  logic [NUM_TMR-1:0] tmr_irq,
  input  logic               wdt_irq,
  input  logic [TS_W-1:0]    tmr_stop,
  output logic               wake_doze,
  output logic               wake_allstop,
  output logic               wake_swstby
);
  logic [NUM_IRQ-1:0] irq_armed;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_arm
    assign irq_armed[g] = irq[g] & irq_wake_en[g];
  end

  logic any_irq, any_tmr, tmr_live;

  always_comb begin
    any_irq      = |irq;
    any_tmr      = |tmr_irq;
    tmr_live     = any_tmr && (tmr_stop == '0);
    wake_doze    = nmi | any_irq | any_tmr | wdt_irq;
    wake_allstop = nmi | any_irq | tmr_live | wdt_irq;
    wake_swstby  = nmi | (|irq_armed);
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en
);
  always_comb begin
    cpu_clk_en = 1'b0;
    per_clk_en = 1'b1;
    osc_en     = 1'b1;
    unique case (state)
      PM_RUN:     cpu_clk_en = 1'b1;
      PM_ALLSTOP: per_clk_en = 1'b0;
      PM_SWSTBY, PM_HWSTBY: begin
        per_clk_en = 1'b0;
        osc_en     = 1'b0;
      end
      default: ;
    endcase
  end

  AST_CPU_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (per_clk_en && osc_en)); // R11
  AST_OSC_OFF_PERIPH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !per_clk_en); // R11
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_pkg::*;
#(
  parameter int NUM_IRQ   = 12,
  parameter int NUM_TMR   = 4,
  parameter int MSTOP_W   = 32,
  parameter int ACS_DC_LO = 24,
  parameter int ACS_DC_HI = 27,
  parameter int TS_LO     = 8,
  parameter int TS_HI     = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stby_n,
  input  logic               sleep_stb,
  input  logic               sby_sel,
  input  logic               acs_en,
  input  logic               slp_inhibit,
  input  logic [MSTOP_W-1:0] mstop,
  input  logic               nmi,
  input  logic [NUM_IRQ-1:0] irq,
  input  logic [NUM_IRQ-1:0] irq_wake_en,
  input  logic [NUM_TMR-1:0] tmr_irq,
  input  logic               wdt_irq,
  output logic [2:0]         mode,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_en
);
  localparam int TS_W = TS_HI - TS_LO + 1;

  pm_state_e st_q, st_d, sleep_tgt;
  logic      wake_doze, wake_allstop, wake_swstby;

  pwr_sleep_decode #(.MSTOP_W(MSTOP_W), .DC_LO(ACS_DC_LO), .DC_HI(ACS_DC_HI)) u_decode (
    .sby_sel (sby_sel),
    .acs_en  (acs_en),
    .mstop   (mstop),
    .target  (sleep_tgt)
  );

  pwr_wake_qual #(.NUM_IRQ(NUM_IRQ), .NUM_TMR(NUM_TMR), .TS_W(TS_W)) u_wake (
    .nmi          (nmi),
    .irq          (irq),
    .irq_wake_en  (irq_wake_en),
    .tmr_irq      (tmr_irq),
    .wdt_irq      (wdt_irq),
    .tmr_stop     (mstop[TS_HI:TS_LO]),
    .wake_doze    (wake_doze),
    .wake_allstop (wake_allstop),
    .wake_swstby  (wake_swstby)
  );

  always_comb begin
    st_d = st_q;
    if (!stby_n) begin
      st_d = PM_HWSTBY;
    end else if (st_q == PM_HWSTBY) begin
      if (!rst_n) st_d = PM_RESET;
    end else if (!rst_n) begin
      st_d = PM_RESET;
    end else begin
      unique case (st_q)
        PM_RESET:   st_d = PM_RUN;
        PM_RUN:     if (sleep_stb && !slp_inhibit) st_d = sleep_tgt;
        PM_DOZE:    if (wake_doze)    st_d = PM_RUN;
        PM_ALLSTOP: if (wake_allstop) st_d = PM_RUN;
        PM_SWSTBY:  if (wake_swstby)  st_d = PM_RUN;
        default:    st_d = PM_RESET;
      endcase
    end
  end

  always_ff @(posedge clk) st_q <= st_d;

  assign mode = st_q;

  pwr_clk_ctrl u_clk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (st_q),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en)
  );

  AST_HWSTBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |=> mode == PM_HWSTBY); // R2
  AST_HWSTBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_HWSTBY) |=> mode == PM_HWSTBY); // R3
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n && mode == PM_RUN && slp_inhibit) |=> mode == PM_RUN); // R4
  AST_SWSTBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stby_n && mode == PM_SWSTBY && !nmi && (irq & irq_wake_en) == '0) |=> mode == PM_SWSTBY); // R9
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst_n)
    (stby_n && mode != PM_HWSTBY) |=> mode == PM_RESET); // R10
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  localparam int NT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, stby_n = 1'b1, sleep_stb = 1'b0, sby_sel = 1'b0, acs_en = 1'b0, slp_inhibit = 1'b0;
  logic [31:0] mstop = '0;
  logic nmi = 1'b0, wdt_irq = 1'b0;
  logic [11:0] irq = '0, irq_wake_en = '0;
  logic [NT-1:0] tmr_irq = '0;
  logic [2:0] mode;
  logic cpu_clk_en, per_clk_en, osc_en;

  pwr_mode_seq #(.NUM_TMR(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sleep_stb(sleep_stb), .sby_sel(sby_sel),
    .acs_en(acs_en), .slp_inhibit(slp_inhibit), .mstop(mstop), .nmi(nmi), .irq(irq),
    .irq_wake_en(irq_wake_en), .tmr_irq(tmr_irq), .wdt_irq(wdt_irq), .mode(mode),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en)
  );

  typedef struct packed {
    logic        ssb, acs, inh;
    logic [31:0] ms;
    logic        n;
    logic [11:0] iq, we;
    logic [1:0]  tm;
    logic        wd;
    logic [2:0]  exp_sleep, exp_wake;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 12'h000, 12'h000, 2'b01, 1'b0, 3'd2, 3'd1}, // R5 R7 doze, timer wake
    '{1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 12'h020, 12'h000, 2'b00, 1'b0, 3'd2, 3'd1}, // R5 acs off -> doze, irq5
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 12'h000, 12'h000, 2'b00, 1'b0, 3'd3, 3'd1}, // R5 R8 nmi
    '{1'b0, 1'b1, 1'b0, 32'hF0FF_FFFF, 1'b0, 12'h000, 12'h000, 2'b10, 1'b0, 3'd3, 3'd3}, // R8 timer gated
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, 12'h000, 12'h000, 2'b00, 1'b1, 3'd2, 3'd1}, // R5 miss -> doze, wdt
    '{1'b0, 1'b1, 1'b0, 32'hF5FF_FFFF, 1'b0, 12'h000, 12'h000, 2'b00, 1'b1, 3'd3, 3'd1}, // R5 R8 dc nibble, wdt
    '{1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 12'h800, 12'h000, 2'b00, 1'b0, 3'd3, 3'd1}, // R8 irq11
    '{1'b0, 1'b1, 1'b0, 32'hEFFF_FFFF, 1'b0, 12'h001, 12'h000, 2'b00, 1'b0, 3'd2, 3'd1}, // R5 bit28 clear
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 12'h008, 12'h000, 2'b00, 1'b0, 3'd4, 3'd4}, // R6 R9 irq3 unenabled
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 12'h008, 12'h008, 2'b00, 1'b0, 3'd4, 3'd1}, // R9 irq3 enabled
    '{1'b1, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 12'h000, 12'hFFF, 2'b11, 1'b1, 3'd4, 3'd4}, // R9 timers+wdt ignored
    '{1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 12'h000, 12'h000, 2'b00, 1'b0, 3'd4, 3'd1}, // R6 over acs, nmi
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 1'b0, 12'h000, 12'h000, 2'b00, 1'b0, 3'd1, 3'd1}  // R4 inhibited
  };

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] exp);
    logic ec, ep, eo;
    ec = (exp == 3'd1);
    ep = !(exp == 3'd3 || exp == 3'd4 || exp == 3'd5);
    eo = !(exp == 3'd4 || exp == 3'd5);
    n_run++;
    if (mode !== exp || cpu_clk_en !== ec || per_clk_en !== ep || osc_en !== eo) begin
      n_fail++;
      $display("FAIL %s: mode=%0d cpu/per/osc=%b%b%b expected mode=%0d %b%b%b",
               req, mode, cpu_clk_en, per_clk_en, osc_en, exp, ec, ep, eo);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stby_n = 1'b1; tick(); tick();
    rst_n = 1'b1; tick();
  endtask

  task automatic strobe();
    sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
  endtask

  task automatic clear_ev();
    nmi = 1'b0; irq = '0; tmr_irq = '0; wdt_irq = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: mode=%0d expected run to finish", mode);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 R11 reset state", 3'd0);
    rst_n = 1'b1; tick();
    chk("R1 reset release", 3'd1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      sby_sel = TBL[i].ssb; acs_en = TBL[i].acs; slp_inhibit = TBL[i].inh; mstop = TBL[i].ms;
      irq_wake_en = TBL[i].we;
      strobe();
      chk("R4 R5 R6 R11 sleep entry", TBL[i].exp_sleep);
      nmi = TBL[i].n; irq = TBL[i].iq; tmr_irq = TBL[i].tm; wdt_irq = TBL[i].wd;
      tick(); clear_ev();
      chk("R7 R8 R9 wake", TBL[i].exp_wake);
    end

    // R8: stop field cleared while in ALLSTOP lets a timer wake it
    do_reset();
    sby_sel = 1'b0; acs_en = 1'b1; slp_inhibit = 1'b0; mstop = 32'hFFFF_FFFF;
    strobe();
    chk("R8 enter allstop", 3'd3);
    mstop = 32'hFFFF_F1FF; tmr_irq = 2'b10; tick(); clear_ev();
    chk("R8 partial stop field keeps timer gated", 3'd3);
    mstop = 32'hFFFF_F0FF; tmr_irq = 2'b01; tick(); clear_ev();
    chk("R8 clear stop field timer wakes", 3'd1);

    // R10: reset against a strobe and against a wake
    mstop = '0; acs_en = 1'b0;
    rst_n = 1'b0; sleep_stb = 1'b1; tick(); sleep_stb = 1'b0;
    chk("R10 reset beats strobe", 3'd0);
    rst_n = 1'b1; tick();
    strobe();
    chk("R5 doze", 3'd2);
    rst_n = 1'b0; nmi = 1'b1; tick(); clear_ev();
    chk("R10 reset beats wake", 3'd0);
    rst_n = 1'b1; tick();

    // R2 / R3 hardware standby
    stby_n = 1'b0; tick();
    chk("R2 standby from run", 3'd5);
    stby_n = 1'b1; tick(); tick();
    chk("R3 held with reset high", 3'd5);
    nmi = 1'b1; tick(); clear_ev();
    chk("R3 wake ignored", 3'd5);
    rst_n = 1'b0; stby_n = 1'b0; tick();
    chk("R2 standby beats reset", 3'd5);
    stby_n = 1'b1; tick();
    chk("R3 exit to reset", 3'd0);
    rst_n = 1'b1; tick();
    chk("R1 run after standby", 3'd1);
    sby_sel = 1'b1; strobe();
    chk("R6 swstby", 3'd4);
    stby_n = 1'b0; tick();
    chk("R2 standby from swstby", 3'd5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule